// File: doc/BRIEF.md
# Dual Trigger Timestamp Capture Queue

This block watches a set of asynchronous trigger pins (two by default) and records the moment each selected edge arrives. Each pin passes through a two-flop synchronizer. When the chosen edge is recognised, the block stores the free-running 64-bit time value from that clock cycle in a queue that belongs to that pin. Software drains each queue through a small register bus. It reads the lower 32 bits of the oldest stamp first and then the upper 32 bits. Reading the upper half removes the entry.

Every queue reports three conditions: it holds data, its fill level is above a shared programmable threshold, and a capture was lost because the queue was full. The lost-capture flag stays set until software clears it. Each condition has its own interrupt enable for each pin, and one interrupt line is the OR of all enabled conditions. The per-pin "holds data" bits also leave the block as a status vector.

Register word addresses:
- 0 is edge select.
- 1 is threshold.
- 2 is interrupt enable.
- 3 is status.
- 4+2c and 5+2c are the low and high stamp words of pin c.

Top module: `trig_stamp_capture`

## Requirements
- R1: A level change on trigger pin c that is sampled at clock edge k is seen as an edge at clock edge k+2. The value of `time_now` present at edge k+2 is appended to queue c at that edge.
- R2: Bit c of the edge-select register (address 0) picks the capture edge for pin c: 0 is rising, 1 is falling. The opposite edge captures nothing.
- R3: Each pin has its own queue of DEPTH entries (16 by default). Stamps come out oldest first, and captures on one pin never enter another pin's queue.
- R4: Reading address 4+2c returns bits 31:0 of the oldest stamp of queue c and leaves the queue unchanged. Reading address 5+2c returns bits 63:32 and removes that entry. Either read of an empty queue returns 0 and removes nothing.
- R5: Status bit c (address 3) and `valid_stat[c]` are 1 exactly when queue c holds at least one stamp. Pin 1's bit sits directly above pin 0's bit.
- R6: The threshold register (address 1, bits 3:0, reset 0) accepts writes of 0 to DEPTH-1. A write of a larger value leaves it unchanged. Status bit NUM_CH+c is 1 while the fill level of queue c is greater than the threshold.
- R7: A capture that arrives while queue c is full, with no removal in the same cycle, is discarded and sets sticky status bit 2*NUM_CH+c. Writing 1 to that bit clears it. If a new loss happens in the same cycle as the clear, the bit stays set.
- R8: A capture and a high-word read of a full queue in the same cycle are both accepted. The level stays at DEPTH and no loss is flagged.
- R9: The interrupt enable register (address 2) holds bit 4c for data present, bit 4c+1 for threshold exceeded and bit 4c+2 for capture lost. `irq` is 1 when any enabled condition is true. Bit 4c+3 reads as 0.
- R10: After reset, all registers, queues and flags are zero, and `irq` and `valid_stat` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | NUM_CH | Asynchronous trigger pins |
| time_now | input | TIME_W | Current time, already in this clock domain |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a high-word read removes an entry) |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the read |
| valid_stat | output | NUM_CH | Per-pin queue not empty |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a capture landing on a full queue in the very cycle that software removes the head entry. The synchronizer delay hides the pin from the register bus. The stimulus first fills queue 0 to the brim. It then toggles the pin and starts a high-word read exactly two clocks later, so that the pop and the push fall on the same edge. A behavioural model with one queue per pin tracks the loss flags, threshold bits, interrupt and read data on every clock, so any lost or duplicated stamp shows up at once.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   // register word offsets; stamp words start at TS_BASE, two per pin
   localparam int unsigned REG_EDGE  = 0;
   localparam int unsigned REG_THR   = 1;
   localparam int unsigned REG_IEN   = 2;
   localparam int unsigned REG_STAT  = 3;
   localparam int unsigned TS_BASE   = 4;
   // bit positions inside one pin's enable nibble
   localparam int unsigned IEN_AVAIL = 0;
   localparam int unsigned IEN_THR   = 1;
   localparam int unsigned IEN_LOST  = 2;
   localparam int unsigned IEN_SPAN  = 4;

   typedef struct packed {
      logic lost;
      logic above;
      logic avail;
   } pin_flags_t;

   function automatic int unsigned lo_word_addr(input int unsigned pin);
      return TS_BASE + 2 * pin;
   endfunction

   function automatic int unsigned hi_word_addr(input int unsigned pin);
      return TS_BASE + 2 * pin + 1;
   endfunction
endpackage

// File: rtl/tsc_edge_sync.sv
module tsc_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic fall_sel,
   output logic hit
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tsc_edge_sync: SYNC_STAGES must be at least 2");
   end

   // chain[0] is the first flop; chain[SYNC_STAGES] holds the previous synced level
   logic [SYNC_STAGES:0] chain;
   logic                 newer;
   logic                 older;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[SYNC_STAGES-1:0], pin};
   end

   assign newer = chain[SYNC_STAGES-1];
   assign older = chain[SYNC_STAGES];
   assign hit   = fall_sel ? (older & ~newer) : (newer & ~older);

   // R1: a recognised edge lasts exactly one cycle
   p_hit_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !hit);
endmodule

// File: rtl/tsc_stamp_fifo.sv
module tsc_stamp_fifo #(
   parameter  int DEPTH = 16,
   parameter  int WIDTH = 64,
   localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LW    = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] head,
   output logic [LW-1:0]    level,
   output logic             drop
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("tsc_stamp_fifo: DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             is_empty, is_full, pop_ok, push_ok;

   assign is_empty = (level == '0);
   assign is_full  = (level == LW'(DEPTH));
   assign pop_ok   = pop && !is_empty;
   assign push_ok  = push && (!is_full || pop_ok);
   assign drop     = push && !push_ok;
   assign head     = is_empty ? '0 : mem[rd_ptr];

   // power-of-two depth wraps for free; otherwise compare against the last slot
   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
      assign wr_nxt = wr_ptr + PW'(1);
      assign rd_nxt = rd_ptr + PW'(1);
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   level <= level + LW'(1);
            2'b01:   level <= level - LW'(1);
            default: level <= level;
         endcase
      end
   end

   // R7: a capture refused while full leaves the queue full
   p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && level == LW'(DEPTH)) |=> (level == LW'(DEPTH)));
   // R8: simultaneous capture and removal on a full queue keeps it full, nothing lost
   p_full_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && level == LW'(DEPTH)) |-> !drop ##1 (level == LW'(DEPTH)));
   // R4: removal from an empty queue changes nothing
   p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && level == '0) |=> (level == '0));
   // R3: level never leaves its legal range
   p_level_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));
endmodule

// File: rtl/trig_stamp_capture.sv
module trig_stamp_capture
   import tsc_pkg::*;
#(
   parameter  int NUM_CH      = 2,
   parameter  int DEPTH       = 16,
   parameter  int TIME_W      = 64,
   parameter  int DATA_W      = 32,
   parameter  int SYNC_STAGES = 2,
   localparam int ADDR_W      = $clog2(TS_BASE + 2 * NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] trig_in,
   input  logic [TIME_W-1:0] time_now,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] valid_stat,
   output logic              irq
);
   localparam int TW = $clog2(DEPTH);
   localparam int LW = $clog2(DEPTH + 1);
   localparam int EW = IEN_SPAN * NUM_CH;

   if (TIME_W != 2 * DATA_W) begin : g_bad_time
      $error("trig_stamp_capture: TIME_W must be twice DATA_W");
   end
   if (NUM_CH < 1 || EW > DATA_W) begin : g_bad_ch
      $error("trig_stamp_capture: NUM_CH out of range for the bus width");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("trig_stamp_capture: DEPTH must be at least 2");
   end

   logic [NUM_CH-1:0] fall_sel;
   logic [TW-1:0]     thr;
   logic [EW-1:0]     ien;
   logic [EW-1:0]     ien_mask;
   logic [NUM_CH-1:0] lost;
   logic [NUM_CH-1:0] above;
   logic [NUM_CH-1:0] hit;
   logic [NUM_CH-1:0] pop;
   logic [NUM_CH-1:0] drop;
   logic [NUM_CH-1:0] cause;
   logic [TIME_W-1:0] head  [NUM_CH];
   logic [LW-1:0]     level [NUM_CH];
   pin_flags_t        flags [NUM_CH];

   logic wr_edge, wr_thr, wr_ien, wr_stat, thr_ok;
   assign wr_edge = bus_wr && (bus_addr == ADDR_W'(REG_EDGE));
   assign wr_thr  = bus_wr && (bus_addr == ADDR_W'(REG_THR));
   assign wr_ien  = bus_wr && (bus_addr == ADDR_W'(REG_IEN));
   assign wr_stat = bus_wr && (bus_addr == ADDR_W'(REG_STAT));
   assign thr_ok  = (bus_wdata <= DATA_W'(DEPTH - 1));

   // per-pin datapath: synchronizer, queue, flags
   for (genvar c = 0; c < NUM_CH; c++) begin : g_pin
      tsc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
         .clk      (clk),
         .rst_n    (rst_n),
         .pin      (trig_in[c]),
         .fall_sel (fall_sel[c]),
         .hit      (hit[c])
      );

      assign pop[c] = bus_rd && (bus_addr == ADDR_W'(hi_word_addr(c)));

      tsc_stamp_fifo #(.DEPTH(DEPTH), .WIDTH(TIME_W)) u_fifo (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (hit[c]),
         .pop   (pop[c]),
         .din   (time_now),
         .head  (head[c]),
         .level (level[c]),
         .drop  (drop[c])
      );

      logic lost_clr;
      assign lost_clr = wr_stat && bus_wdata[2*NUM_CH+c];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lost[c] <= 1'b0;
         else        lost[c] <= drop[c] | (lost[c] & ~lost_clr);
      end

      assign valid_stat[c]  = (level[c] != '0);
      assign above[c]       = (level[c] > LW'(thr));
      assign flags[c].avail = valid_stat[c];
      assign flags[c].above = above[c];
      assign flags[c].lost  = lost[c];

      assign ien_mask[IEN_SPAN*c +: IEN_SPAN] =
         IEN_SPAN'((1 << IEN_AVAIL) | (1 << IEN_THR) | (1 << IEN_LOST));

      assign cause[c] = (flags[c].avail & ien[IEN_SPAN*c+IEN_AVAIL])
                      | (flags[c].above & ien[IEN_SPAN*c+IEN_THR])
                      | (flags[c].lost  & ien[IEN_SPAN*c+IEN_LOST]);

      // R7: a lost capture always shows up as a sticky flag
      p_lost_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
         drop[c] |=> lost[c]);
      // R7: the flag only falls through a write-one clear
      p_lost_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (lost[c] && !lost_clr) |=> lost[c]);
      // R9: an enabled data-present condition reaches the interrupt line
      p_avail_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_stat[c] && ien[IEN_SPAN*c+IEN_AVAIL]) |-> irq);
   end

   assign irq = |cause;

   // control registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fall_sel <= '0;
         thr      <= '0;
         ien      <= '0;
      end else begin
         if (wr_edge)           fall_sel <= bus_wdata[NUM_CH-1:0];
         if (wr_thr && thr_ok)  thr      <= bus_wdata[TW-1:0];
         if (wr_ien)            ien      <= bus_wdata[EW-1:0] & ien_mask;
      end
   end

   // read mux
   logic [DATA_W-1:0] stat_word;
   always_comb begin
      stat_word = '0;
      stat_word[NUM_CH-1:0]          = valid_stat;
      stat_word[2*NUM_CH-1:NUM_CH]   = above;
      stat_word[3*NUM_CH-1:2*NUM_CH] = lost;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(REG_EDGE)) bus_rdata = DATA_W'(fall_sel);
      if (bus_addr == ADDR_W'(REG_THR))  bus_rdata = DATA_W'(thr);
      if (bus_addr == ADDR_W'(REG_IEN))  bus_rdata = DATA_W'(ien);
      if (bus_addr == ADDR_W'(REG_STAT)) bus_rdata = stat_word;
      for (int c = 0; c < NUM_CH; c++) begin
         if (bus_addr == ADDR_W'(lo_word_addr(c))) bus_rdata = head[c][DATA_W-1:0];
         if (bus_addr == ADDR_W'(hi_word_addr(c))) bus_rdata = head[c][TIME_W-1:DATA_W];
      end
   end

   // R6: an out-of-range threshold write leaves the register alone
   p_thr_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_thr && !thr_ok) |=> $stable(thr));
   // R10: nothing can interrupt while every enable is off
   p_quiet_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ien == '0) |-> !irq);
endmodule

// File: tb/trig_stamp_capture_bench.sv
module trig_stamp_capture_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  trig_in = '0;
   logic [63:0] time_now = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  valid_stat;
   logic        irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   longint tcount = 0;

   trig_stamp_capture u_trig_stamp_capture (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .time_now(time_now),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .valid_stat(valid_stat), .irq(irq)
   );

   always #2 clk = ~clk;   // 250 MHz

   always @(negedge clk) begin
      tcount   = tcount + 1;
      time_now = 64'h0000_0100_0000_0000 + 64'(tcount) * 64'h0000_0001_0000_0003;
   end

   // behavioural reference
   logic [63:0] q0[$];
   logic [63:0] q1[$];
   bit [1:0] ms1, ms2, ms3, mpol, movf;
   int       mthr;
   bit [7:0] mien;

   always @(posedge clk) begin
      if (!rst_n) begin
         q0.delete(); q1.delete();
         ms1 = 0; ms2 = 0; ms3 = 0; mpol = 0; movf = 0; mthr = 0; mien = 0;
      end else begin
         bit [1:0] e;
         bit [1:0] nov;
         for (int c = 0; c < 2; c++)
            e[c] = mpol[c] ? (!ms2[c] && ms3[c]) : (ms2[c] && !ms3[c]);
         nov = movf;
         if (bus_wr && bus_addr == 3'd3) nov = nov & ~bus_wdata[5:4];
         if (bus_rd && bus_addr == 3'd5 && q0.size() > 0) void'(q0.pop_front());
         if (bus_rd && bus_addr == 3'd7 && q1.size() > 0) void'(q1.pop_front());
         if (e[0]) begin if (q0.size() < 16) q0.push_back(time_now); else nov[0] = 1; end
         if (e[1]) begin if (q1.size() < 16) q1.push_back(time_now); else nov[1] = 1; end
         movf = nov;
         if (bus_wr && bus_addr == 3'd0) mpol = bus_wdata[1:0];
         if (bus_wr && bus_addr == 3'd1 && bus_wdata <= 32'd15) mthr = int'(bus_wdata);
         if (bus_wr && bus_addr == 3'd2) mien = bus_wdata[7:0] & 8'h77;
         ms3 = ms2; ms2 = ms1; ms1 = trig_in;
      end
   end

   function automatic bit [1:0] m_valid();
      return {q1.size() > 0, q0.size() > 0};
   endfunction
   function automatic bit [1:0] m_above();
      return {q1.size() > mthr, q0.size() > mthr};
   endfunction
   function automatic logic [31:0] m_stat();
      return {26'b0, movf, m_above(), m_valid()};
   endfunction
   function automatic logic m_irq();
      bit [1:0] v = m_valid(), a = m_above();
      return (v[0] & mien[0]) | (a[0] & mien[1]) | (movf[0] & mien[2])
           | (v[1] & mien[4]) | (a[1] & mien[5]) | (movf[1] & mien[6]);
   endfunction
   function automatic logic [31:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return {30'b0, mpol};
         3'd1: return 32'(mthr);
         3'd2: return {24'b0, mien};
         3'd3: return m_stat();
         3'd4: return (q0.size() > 0) ? q0[0][31:0]  : 32'h0;
         3'd5: return (q0.size() > 0) ? q0[0][63:32] : 32'h0;
         3'd6: return (q1.size() > 0) ? q1[0][31:0]  : 32'h0;
         default: return (q1.size() > 0) ? q1[0][63:32] : 32'h0;
      endcase
   endfunction

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // every-clock comparison, settled after the falling edge
   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         chk(64'(valid_stat), 64'(m_valid()), "R5 valid_stat");
         chk(64'(irq), 64'(m_irq()), "R9 irq");
         if (bus_rd) chk(64'(bus_rdata), 64'(m_read(bus_addr)), "R4 read data");
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
      @(negedge clk); bus_rd = 1; bus_addr = a;
      #1 chk(64'(bus_rdata), 64'(exp), req);
      @(negedge clk); bus_rd = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input int c);
      @(negedge clk); trig_in[c] = 1; idle(4);
      trig_in[c] = 0; idle(4);
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      failures++;
      $display("FAIL watchdog expired");
      done = 1;
      report();
   end

   initial begin
      logic [63:0] first0;
      idle(3);
      rst_n = 1;
      idle(2);
      // R10: reset state
      chk(64'(valid_stat), 0, "R10 valid after reset");
      chk(64'(irq), 0, "R10 irq after reset");
      rd_chk(3'd3, 32'h0, "R10 status after reset");
      rd_chk(3'd1, 32'h0, "R10 threshold after reset");

      // R1/R3: rising capture on pin 0, read low then high
      pulse(0);
      chk(64'(valid_stat), 64'b01, "R1 capture on pin 0");
      first0 = q0[0];
      rd_chk(3'd4, first0[31:0], "R4 low word");
      chk(64'(q0.size()), 1, "R4 low word does not remove");
      rd_chk(3'd5, first0[63:32], "R4 high word");
      chk(64'(valid_stat), 0, "R4 high word removes");

      // R4: empty reads return zero and remove nothing
      rd_chk(3'd5, 32'h0, "R4 empty high read");
      rd_chk(3'd6, 32'h0, "R4 empty low read");

      // R2: falling edge select on pin 1
      wr(3'd0, 32'h2);
      @(negedge clk); trig_in[1] = 1; idle(5);
      chk(64'(valid_stat[1]), 0, "R2 rising ignored when falling selected");
      trig_in[1] = 0; idle(5);
      chk(64'(valid_stat[1]), 1, "R2 falling captured");

      // R3: simultaneous pins, pin 0 rising, pin 1 falling
      @(negedge clk); trig_in = 2'b11; idle(4); trig_in = 2'b00; idle(5);
      chk(64'(q1.size()), 2, "R3 pin 1 queue depth");
      chk(64'(q0.size()), 1, "R3 pin 0 independent");
      rd_chk(3'd7, q1[0][63:32], "R3 oldest first");

      // R6: threshold reject and compare
      wr(3'd1, 32'd3);
      wr(3'd1, 32'd20);
      rd_chk(3'd1, 32'd3, "R6 large threshold rejected");
      repeat (3) pulse(0);
      rd_chk(3'd3, m_stat(), "R6 above flag");
      chk(64'(m_above()), 64'b01, "R6 pin 0 above threshold");

      // R9: enables
      wr(3'd2, 32'hFF);
      rd_chk(3'd2, 32'h77, "R9 reserved enable bits read zero");
      idle(2);
      chk(64'(irq), 1, "R9 irq with enables");
      wr(3'd2, 32'h0);
      idle(2);
      chk(64'(irq), 0, "R9 irq masked");

      // R7: overflow on pin 0
      wr(3'd0, 32'h2);
      repeat (13) pulse(0);
      chk(64'(q0.size()), 16, "R3 pin 0 full");
      pulse(0);
      rd_chk(3'd3, m_stat(), "R7 loss flag set");
      chk(64'(movf[0]), 1, "R7 model loss");
      wr(3'd2, 32'h4);
      idle(2);
      chk(64'(irq), 1, "R9 loss interrupt");
      wr(3'd3, 32'h10);
      rd_chk(3'd3, m_stat(), "R7 write-one clear");
      chk(64'(movf[0]), 0, "R7 cleared");

      // R8: capture and removal in the same cycle on a full queue
      @(negedge clk); trig_in[0] = 1;
      @(negedge clk);
      @(negedge clk); bus_rd = 1; bus_addr = 3'd5;
      @(negedge clk); bus_rd = 0;
      idle(2);
      chk(64'(q0.size()), 16, "R8 level stays full");
      rd_chk(3'd3, m_stat(), "R8 no loss flagged");
      chk(64'(movf[0]), 0, "R8 loss flag clear");
      trig_in[0] = 0; idle(4);

      // drain pin 0 and check order through the every-clock compare
      for (int i = 0; i < 17; i++) rd_chk(3'd5, m_read(3'd5), "R3 drain order");
      chk(64'(valid_stat[0]), 0, "R5 pin 0 drained");

      done = 1;
      idle(2);
      report();
   end
endmodule